// File: doc/BRIEF.md
# Region Protection and Translation Unit

This block guards and optionally relocates a 32-bit address space that is cut into eight equal regions of 512 MB each. The top three address bits select the region. Each region has a 4-bit attribute and a 3-bit physical region base. The unit keeps two independent copies of this table. One serves instruction fetches and the other serves loads and stores. For every access the unit decodes the attribute of the selected region into read, write and execute permissions. It then returns either the physical address or a fault with a cause code that names the kind of access that was refused.

Accesses enter on a valid/ready request stream and leave on a valid/ready response stream. There is one response register between them. A request is taken when `acc_valid` and `acc_ready` are both high at a clock edge, and its response appears on the next cycle. `acc_ready` is high whenever the response register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged and no new request is taken.

Table maintenance uses a plain control port. It can write an entry, read an entry back in either of two forms, or probe an address. The result of each operation comes out one cycle later. The attribute bits carry only their permission meaning; no cache behaviour is modelled. The parameter `XLATE_EN` decides whether table writes may change the physical region base.

Top module: `rgn_prot_unit`

## Requirements
- R1: After reset, every region on both sides maps to its own index and holds attribute 2. `acc_ready` is 1, `rsp_valid` is 0 and `op_rvalid` is 0.
- R2: The region index is `acc_vaddr[31:29]`. On an allowed access, `rsp_paddr` is the region's 3-bit physical base followed by `acc_vaddr[28:0]`.
- R3: Loads and stores are allowed when the data-side attribute is 0, 1, 2, 4, 5 or 14. All other attribute values deny them.
- R4: A fetch is allowed only when the instruction-side attribute is 1, 2, 3, 4 or 5.
- R5: A denied access sets `rsp_fault`=1 and `rsp_paddr`=0. The cause is 28 for a load, 29 for a store and 20 for a fetch. An allowed access gives `rsp_fault`=0 and `rsp_cause`=0.
- R6: A write operation (`op_code`=0) always sets the entry's attribute to `op_wdata[3:0]`. It sets the physical base to `op_wdata[31:29]` only when `XLATE_EN`=1; otherwise the base keeps its reset value.
- R7: Every operation raises `op_rvalid` on the following cycle. Codes 1, 2 and 3 drive `op_rdata` as follows, and a write gives 0.
  - Code 1 returns `op_addr & 32'hE000_0000`.
  - Code 2 returns `{base, 29'b0} | attribute`.
  - Code 3 (probe) returns `(op_addr & 32'hE000_0000) | 1`.
- R8: `acc_kind` 0 is a load, 1 is a store, and 2 or 3 is a fetch. Fetches consult only the instruction table (`op_dside`=0), and loads and stores only the data table (`op_dside`=1). A write to one side leaves the other side unchanged.
- R9: `acc_ready` = !`rsp_valid` || `rsp_ready`. A response is valid in the cycle after its request is taken. It holds stable while stalled, and responses leave in request order.
- R10: An access taken in the same cycle as a write to its own entry sees the entry contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request can be taken |
| acc_vaddr | input | 32 | Virtual address of the access |
| acc_kind | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Access was denied |
| rsp_cause | output | 6 | Fault cause, 0 when allowed |
| op_valid | input | 1 | Maintenance operation strobe |
| op_code | input | 2 | 0 write, 1 read address form, 2 read entry, 3 probe |
| op_dside | input | 1 | 0 instruction table, 1 data table |
| op_addr | input | 32 | Address that selects the region |
| op_wdata | input | 32 | Write data: base in [31:29], attribute in [3:0] |
| op_rvalid | output | 1 | Operation result valid |
| op_rdata | output | 32 | Operation result |

## Verification
On every cycle, the assertions check the response handshake: a response follows each taken request and is held stable while stalled. They also check that a fault never carries an address and that a success never carries a cause. They check that a written entry holds the written attribute on the next cycle, and that an operation's result strobe follows it.

The bench scenarios are what show the actual permission decode for all sixteen attribute values on both tables, and the cause chosen for each access kind. They also show remapping under both settings of the translation parameter, isolation between the two tables, the exact read-back and probe words, and the old-contents ordering when a write and an access hit the same entry in the same cycle.

// File: rtl/rgn_pkg.sv
`timescale 1ns/1ps
package rgn_pkg;
  localparam int CAUSE_W = 6;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 6'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_FETCH = 6'd20;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 6'd28;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE = 6'd29;

  typedef enum logic [1:0] {
    OP_WRITE    = 2'd0,
    OP_RD_VADDR = 2'd1,
    OP_RD_ENTRY = 2'd2,
    OP_PROBE    = 2'd3
  } op_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;
endpackage

// File: rtl/rgn_attr_decode.sv
`timescale 1ns/1ps
module rgn_attr_decode
  import rgn_pkg::*;
#(
  parameter int ATTR_W = 4
) (
  input  logic [ATTR_W-1:0] attr,
  output perm_t             perm
);
  logic data_ok;
  logic exec_ok;

  always_comb begin
    data_ok = ((attr < ATTR_W'(6)) && (attr != ATTR_W'(3))) || (attr == ATTR_W'(14));
    exec_ok = (attr >= ATTR_W'(1)) && (attr <= ATTR_W'(5));
    perm.rd = data_ok;
    perm.wr = data_ok;
    perm.ex = exec_ok;
  end
endmodule

// File: rtl/rgn_table.sv
`timescale 1ns/1ps
module rgn_table #(
  parameter int REGION_BITS = 3,
  parameter int ATTR_W      = 4,
  parameter bit XLATE_EN    = 1'b1,
  parameter int RESET_ATTR  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [REGION_BITS-1:0] wr_idx,
  input  logic [ATTR_W-1:0]      wr_attr,
  input  logic [REGION_BITS-1:0] wr_pbase,
  input  logic [REGION_BITS-1:0] lk_idx,
  output logic [ATTR_W-1:0]      lk_attr,
  output logic [REGION_BITS-1:0] lk_pbase,
  input  logic [REGION_BITS-1:0] rb_idx,
  output logic [ATTR_W-1:0]      rb_attr,
  output logic [REGION_BITS-1:0] rb_pbase
);
  localparam int NUM = 1 << REGION_BITS;

  logic [ATTR_W-1:0]      attr_all [NUM];
  logic [REGION_BITS-1:0] pb_all   [NUM];

  for (genvar e = 0; e < NUM; e++) begin : g_ent
    logic hit;
    logic [ATTR_W-1:0] a_q;
    assign hit = wr_en && (wr_idx == REGION_BITS'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   a_q <= ATTR_W'(RESET_ATTR);
      else if (hit) a_q <= wr_attr;
    end
    assign attr_all[e] = a_q;

    if (XLATE_EN) begin : g_xl
      logic [REGION_BITS-1:0] p_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   p_q <= REGION_BITS'(e);
        else if (hit) p_q <= wr_pbase;
      end
      assign pb_all[e] = p_q;
    end else begin : g_fixed
      assign pb_all[e] = REGION_BITS'(e);
    end

    // R6: a written entry holds the written attribute on the next cycle
    a_r6_attr_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (a_q == $past(wr_attr)));
  end

  if (!XLATE_EN) begin : g_nouse
    logic unused_pbase;
    assign unused_pbase = ^wr_pbase;
  end

  assign lk_attr  = attr_all[lk_idx];
  assign lk_pbase = pb_all[lk_idx];
  assign rb_attr  = attr_all[rb_idx];
  assign rb_pbase = pb_all[rb_idx];
endmodule

// File: rtl/rgn_resp_stage.sv
`timescale 1ns/1ps
module rgn_resp_stage #(
  parameter int DATA_W = 39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic fire;
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9: a taken request produces a response on the next cycle
  a_r9_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R9: a stalled response stays valid and unchanged
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/rgn_prot_unit.sv
`timescale 1ns/1ps
module rgn_prot_unit
  import rgn_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 3,
  parameter int ATTR_W      = 4,
  parameter bit XLATE_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_vaddr,
  input  logic [1:0]        acc_kind,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic              op_dside,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [ADDR_W-1:0] op_wdata,
  output logic              op_rvalid,
  output logic [ADDR_W-1:0] op_rdata
);
  localparam int OFFS_W  = ADDR_W - REGION_BITS;
  localparam int RESP_W  = ADDR_W + 1 + CAUSE_W;
  localparam int SIDES   = 2;
  localparam logic [ADDR_W-1:0] RGN_MASK = {{REGION_BITS{1'b1}}, {OFFS_W{1'b0}}};

  // access decode
  logic [REGION_BITS-1:0] acc_idx;
  logic                   is_fetch;
  logic                   is_store;
  assign acc_idx  = acc_vaddr[ADDR_W-1 -: REGION_BITS];
  assign is_fetch = acc_kind[1];
  assign is_store = !acc_kind[1] && acc_kind[0];

  // maintenance decode
  op_e                    op_sel;
  logic [REGION_BITS-1:0] op_idx;
  assign op_sel = op_e'(op_code);
  assign op_idx = op_addr[ADDR_W-1 -: REGION_BITS];

  // side 0 = instruction table, side 1 = data table
  logic [ATTR_W-1:0]      lk_attr_s  [SIDES];
  logic [REGION_BITS-1:0] lk_pbase_s [SIDES];
  logic [ATTR_W-1:0]      rb_attr_s  [SIDES];
  logic [REGION_BITS-1:0] rb_pbase_s [SIDES];

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic wr_en;
    assign wr_en = op_valid && (op_sel == OP_WRITE) && (op_dside == 1'(s));

    rgn_table #(
      .REGION_BITS (REGION_BITS),
      .ATTR_W      (ATTR_W),
      .XLATE_EN    (XLATE_EN)
    ) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (op_idx),
      .wr_attr  (op_wdata[ATTR_W-1:0]),
      .wr_pbase (op_wdata[ADDR_W-1 -: REGION_BITS]),
      .lk_idx   (acc_idx),
      .lk_attr  (lk_attr_s[s]),
      .lk_pbase (lk_pbase_s[s]),
      .rb_idx   (op_idx),
      .rb_attr  (rb_attr_s[s]),
      .rb_pbase (rb_pbase_s[s])
    );
  end

  logic unused_wdata;
  assign unused_wdata = ^op_wdata[OFFS_W-1:ATTR_W];

  // permission check on the table selected by access kind
  logic [ATTR_W-1:0]      sel_attr;
  logic [REGION_BITS-1:0] sel_pbase;
  perm_t                  perm;
  assign sel_attr  = is_fetch ? lk_attr_s[0]  : lk_attr_s[1];
  assign sel_pbase = is_fetch ? lk_pbase_s[0] : lk_pbase_s[1];

  rgn_attr_decode #(.ATTR_W(ATTR_W)) u_dec (
    .attr (sel_attr),
    .perm (perm)
  );

  logic               allow;
  logic [CAUSE_W-1:0] deny_cause;
  logic [RESP_W-1:0]  resp_next;
  logic [RESP_W-1:0]  resp_q;

  always_comb begin
    if (is_fetch) begin
      allow      = perm.ex;
      deny_cause = CAUSE_FETCH;
    end else if (is_store) begin
      allow      = perm.wr;
      deny_cause = CAUSE_STORE;
    end else begin
      allow      = perm.rd;
      deny_cause = CAUSE_LOAD;
    end
    if (allow) resp_next = {sel_pbase, acc_vaddr[OFFS_W-1:0], 1'b0, CAUSE_NONE};
    else       resp_next = {{ADDR_W{1'b0}}, 1'b1, deny_cause};
  end

  rgn_resp_stage #(.DATA_W(RESP_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (acc_valid),
    .in_ready  (acc_ready),
    .in_data   (resp_next),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (resp_q)
  );

  assign rsp_paddr = resp_q[RESP_W-1 -: ADDR_W];
  assign rsp_fault = resp_q[CAUSE_W];
  assign rsp_cause = resp_q[CAUSE_W-1:0];

  // maintenance results
  logic [ATTR_W-1:0]      rb_attr;
  logic [REGION_BITS-1:0] rb_pbase;
  logic [ADDR_W-1:0]      op_res;
  assign rb_attr  = op_dside ? rb_attr_s[1]  : rb_attr_s[0];
  assign rb_pbase = op_dside ? rb_pbase_s[1] : rb_pbase_s[0];

  always_comb begin
    case (op_sel)
      OP_RD_VADDR: op_res = op_addr & RGN_MASK;
      OP_RD_ENTRY: op_res = {rb_pbase, {OFFS_W{1'b0}}} | {{(ADDR_W-ATTR_W){1'b0}}, rb_attr};
      OP_PROBE:    op_res = (op_addr & RGN_MASK) | ADDR_W'(1);
      default:     op_res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_rvalid <= 1'b0;
      op_rdata  <= '0;
    end else begin
      op_rvalid <= op_valid;
      if (op_valid) op_rdata <= op_res;
    end
  end

  // R5: a denied access never carries an address, and always carries a cause
  a_r5_fault_no_paddr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> ((rsp_paddr == '0) && (rsp_cause != CAUSE_NONE)));

  // R5: an allowed access carries no cause
  a_r5_ok_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_cause == CAUSE_NONE));

  // R7: every operation is answered on the next cycle
  a_r7_op_answered: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> op_rvalid);

  // R9: ready follows the response register occupancy
  a_r9_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !acc_ready);
endmodule

// File: tb/rgn_prot_unit_test.sv
`timescale 1ns/1ps
module rgn_prot_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_vaddr = '0;
  logic [1:0]  acc_kind = '0;
  logic        rsp_ready = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = '0;
  logic        op_dside = 1'b0;
  logic [31:0] op_addr = '0;
  logic [31:0] op_wdata = '0;

  logic        acc_ready, rsp_valid, rsp_fault, op_rvalid;
  logic [31:0] rsp_paddr, op_rdata;
  logic [5:0]  rsp_cause;

  logic        nx_acc_ready, nx_rsp_valid, nx_rsp_fault, nx_op_rvalid;
  logic [31:0] nx_rsp_paddr, nx_op_rdata;
  logic [5:0]  nx_rsp_cause;

  always #2.5 clk = ~clk;

  rgn_prot_unit #(.XLATE_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_vaddr(acc_vaddr), .acc_kind(acc_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .op_valid(op_valid), .op_code(op_code), .op_dside(op_dside), .op_addr(op_addr),
    .op_wdata(op_wdata), .op_rvalid(op_rvalid), .op_rdata(op_rdata)
  );

  rgn_prot_unit #(.XLATE_EN(1'b0)) uut_nx (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(nx_acc_ready), .acc_vaddr(acc_vaddr), .acc_kind(acc_kind),
    .rsp_valid(nx_rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(nx_rsp_paddr),
    .rsp_fault(nx_rsp_fault), .rsp_cause(nx_rsp_cause),
    .op_valid(op_valid), .op_code(op_code), .op_dside(op_dside), .op_addr(op_addr),
    .op_wdata(op_wdata), .op_rvalid(nx_op_rvalid), .op_rdata(nx_op_rdata)
  );

  int checks = 0;
  int errors = 0;

  // reference model of both tables (side 0 instruction, side 1 data)
  logic [3:0] m_attr [2][8];
  logic [2:0] m_pb   [2][8];

  logic [38:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [38:0] exp_acc(input logic [31:0] va, input logic [1:0] k);
    int side;
    logic [2:0] idx;
    logic [3:0] a;
    logic rw, x, ok;
    logic [5:0] cause;
    side  = k[1] ? 0 : 1;
    idx   = va[31:29];
    a     = m_attr[side][idx];
    rw    = ((a < 6) && (a != 3)) || (a == 14);
    x     = (a >= 1) && (a <= 5);
    ok    = k[1] ? x : rw;
    cause = k[1] ? 6'd20 : (k[0] ? 6'd29 : 6'd28);
    return ok ? {m_pb[side][idx], va[28:0], 1'b0, 6'd0} : {32'd0, 1'b1, cause};
  endfunction

  // monitor: pops expected responses as they are handed over
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R9: actual unexpected response %h expected none", rsp_paddr);
      end else begin
        logic [38:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {25'd0, rsp_paddr, rsp_fault, rsp_cause}, {25'd0, e});
      end
    end
  end

  task automatic send_acc(input logic [31:0] va, input logic [1:0] k, input string tag);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_vaddr = va;
    acc_kind  = k;
    exp_q.push_back(exp_acc(va, k));
    tag_q.push_back(tag);
    #1;
    while (!acc_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 acc_valid = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] code, input logic side, input logic [31:0] addr,
                       input logic [31:0] wdata, output logic [31:0] rd, output logic [31:0] rd_nx);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = code;
    op_dside = side;
    op_addr  = addr;
    op_wdata = wdata;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R7", {63'd0, op_rvalid}, 64'd1);
    rd    = op_rdata;
    rd_nx = nx_op_rdata;
    if (code == 2'd0) begin
      m_attr[side][addr[31:29]] = wdata[3:0];
      m_pb[side][addr[31:29]]   = wdata[31:29];
    end
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #1 rsp_ready = v;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd, rdn;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++) begin
        m_attr[s][i] = 4'd2;
        m_pb[s][i]   = 3'(i);
      end

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle state after reset
    chk("R1", {63'd0, rsp_valid}, 64'd0);
    chk("R1", {63'd0, op_rvalid}, 64'd0);
    chk("R1", {63'd0, acc_ready}, 64'd1);

    // R1: identity map with attribute 2 on both sides
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++) begin
        do_op(2'd2, 1'(s), {3'(i), 29'h0ABCDEF}, 32'd0, rd, rdn);
        chk("R1", {32'd0, rd}, {32'd0, 3'(i), 29'd2});
      end

    // R2: default accesses of each kind
    send_acc(32'h2345_6788, 2'd0, "R2");
    send_acc(32'hE000_0010, 2'd2, "R2");
    send_acc(32'h5FFF_FFFC, 2'd1, "R2");

    // R3, R4, R5: all attribute values on region 3
    for (int a = 0; a < 16; a++) begin
      do_op(2'd0, 1'b1, 32'h6000_0000, 32'h6000_0000 | 32'(a), rd, rdn);
      do_op(2'd2, 1'b1, 32'h6000_0000, 32'd0, rd, rdn);
      chk("R6", {32'd0, rd}, {32'd0, 32'h6000_0000 | 32'(a)});
      send_acc(32'h6000_0100, 2'd0, "R3");
      send_acc(32'h6000_0100, 2'd1, "R5");
      do_op(2'd0, 1'b0, 32'h6000_0000, 32'h6000_0000 | 32'(a), rd, rdn);
      send_acc(32'h6000_0104, 2'd2, "R4");
      send_acc(32'h6000_0104, 2'd3, "R8");
    end
    do_op(2'd0, 1'b1, 32'h6000_0000, 32'h6000_0002, rd, rdn);
    do_op(2'd0, 1'b0, 32'h6000_0000, 32'h6000_0002, rd, rdn);

    // R6: remap data region 5 onto base 2
    do_op(2'd0, 1'b1, 32'hA000_0000, 32'h4000_0004, rd, rdn);
    do_op(2'd2, 1'b1, 32'hA000_0000, 32'd0, rd, rdn);
    chk("R6", {32'd0, rd}, {32'd0, 32'h4000_0004});
    chk("R6", {32'd0, rdn}, {32'd0, 32'hA000_0004});
    send_acc(32'hA012_3456, 2'd0, "R2");
    // R8: the instruction table still maps region 5 to itself
    send_acc(32'hA012_3456, 2'd2, "R8");

    // R8: deny fetch on instruction region 4 only
    do_op(2'd0, 1'b0, 32'h8000_0000, 32'h8000_000F, rd, rdn);
    send_acc(32'h8000_0000, 2'd2, "R8");
    send_acc(32'h8000_0010, 2'd0, "R8");
    do_op(2'd2, 1'b1, 32'h8000_0000, 32'd0, rd, rdn);
    chk("R8", {32'd0, rd}, {32'd0, 32'h8000_0002});

    // R7: read-back address form and probe
    do_op(2'd1, 1'b1, 32'h7FFF_FFFF, 32'd0, rd, rdn);
    chk("R7", {32'd0, rd}, {32'd0, 32'h6000_0000});
    do_op(2'd3, 1'b0, 32'h7FFF_FFFF, 32'd0, rd, rdn);
    chk("R7", {32'd0, rd}, {32'd0, 32'h6000_0001});
    do_op(2'd0, 1'b1, 32'hC000_0000, 32'hC000_0002, rd, rdn);
    chk("R7", {32'd0, rd}, 64'd0);

    // R9: back-pressure holds the first response and blocks the second
    set_ready(1'b0);
    send_acc(32'h0000_1234, 2'd0, "R9");
    repeat (3) begin
      @(negedge clk);
      chk("R9", {63'd0, rsp_valid}, 64'd1);
      chk("R9", {32'd0, rsp_paddr}, {32'd0, 32'h0000_1234});
    end
    fork
      send_acc(32'h2000_0008, 2'd1, "R9");
    join_none
    repeat (2) @(negedge clk);
    #1 chk("R9", {63'd0, acc_ready}, 64'd0);
    set_ready(1'b1);
    wait fork;

    // R10: access and write to the same entry in one cycle
    @(negedge clk);
    op_valid  = 1'b1;
    op_code   = 2'd0;
    op_dside  = 1'b1;
    op_addr   = 32'h2000_0000;
    op_wdata  = 32'h2000_000F;
    acc_valid = 1'b1;
    acc_vaddr = 32'h2000_0040;
    acc_kind  = 2'd0;
    exp_q.push_back(exp_acc(32'h2000_0040, 2'd0));
    tag_q.push_back("R10");
    #1 chk("R10", {63'd0, acc_ready}, 64'd1);
    @(posedge clk);
    #1;
    op_valid  = 1'b0;
    acc_valid = 1'b0;
    m_attr[1][1] = 4'hF;
    send_acc(32'h2000_0040, 2'd0, "R10");

    repeat (5) @(negedge clk);
    chk("R9", 64'(exp_q.size()), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule